// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit, Two Reset Levels and Idle Power-Down

This block buffers words between a write clock domain and an unrelated read clock domain. Writers push a word with `wr_en`, and readers take one with `rd_en`. The block reports occupancy through full, empty, half-full, almost-full and almost-empty outputs. The almost thresholds come from two level inputs that an external offset register block provides.

The output timing mode is captured while the master reset input is low. In standard mode, a word is taken only when a read is requested. In fall-through mode, the oldest word is moved to the output register without any request, and two flag pins change meaning: the empty pin becomes output-ready and the full pin becomes input-ready. Master reset clears both pointers and captures the mode. Partial reset clears both pointers and keeps the mode. A retransmit input moves the read pointer back to the first memory location, so stored data can be read again. An idle detector raises a power-down indication after a run of cycles with no activity, and drops it as soon as either enable is raised.

Pointers cross between the clock domains as Gray code through two-flop synchronizers. The read side contains a state machine with two states, `RS_IDLE` and `RS_HELD`:
- In `RS_IDLE` with fall-through mode and the memory not empty, it loads a word and goes to `RS_HELD`.
- In `RS_HELD`, a read with the memory not empty reloads and stays in `RS_HELD`.
- In `RS_HELD`, a read with the memory empty goes back to `RS_IDLE`.
- A retransmit forces `RS_IDLE`.

The idle detector contains a state machine with two states, `PD_AWAKE` and `PD_ASLEEP`:
- It goes from `PD_AWAKE` to `PD_ASLEEP` after `IDLE_LIMIT` consecutive idle edges.
- It goes from `PD_ASLEEP` to `PD_AWAKE` on the first activity.

Top module: `dcfifo_rt`

## Requirements
- R1: Master reset (`mrst_n` low) clears both pointers and `rd_data`, and captures `fwft_sel` as the mode (1 = fall-through, 0 = standard). After it, in standard mode: `empty_or`=1, `full_ir`=0, `half_full`=0, `almost_full`=0, `almost_empty`=1. In fall-through mode: `empty_or`=0 and `full_ir`=1.
- R2: In standard mode, `rd_en` at a read clock edge while the memory is not empty puts the oldest word on `rd_data` after that edge. Words leave in the order they were written.
- R3: A write while full stores nothing. A standard-mode read while empty leaves `rd_data` and the read pointer unchanged.
- R4: `full_ir` (standard mode) is 1 exactly when the memory holds DEPTH words. `empty_or` (standard mode) is 1 exactly when it holds none.
- R5: `half_full` is 1 when the memory holds more than DEPTH/2 words.
- R6: `almost_empty` is 1 when the stored word count is at most `ae_level`. `almost_full` is 1 when DEPTH minus the count is at most `af_level`. In fall-through mode, the word in the output register is not counted.
- R7: `retx_n` low at a read clock edge sets the read pointer to the first memory location. Later reads repeat the data from the start, and the empty-side flags follow the restored pointer. Writes are not blocked.
- R8: Partial reset (`prst_n` low) clears both pointers, the flags and `rd_data`, but keeps the captured mode, even if `fwft_sel` has changed.
- R9: In fall-through mode, the oldest word appears on `rd_data` without `rd_en`, and `empty_or` acts as output-ready (1 = word valid). Each `rd_en` replaces the word with the next one, or clears output-ready if none is stored. `full_ir` acts as input-ready (1 = not full).
- R10: `pwr_down` rises after IDLE_LIMIT (default 10) consecutive edges of the counting clock with no local enable and no pointer movement from the other domain.
- R11: Raising `wr_en` or `rd_en` drops `pwr_down` at once, without waiting for a clock edge. The idle count then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| mrst_n | input | 1 | Master reset, active low, captures mode |
| prst_n | input | 1 | Partial reset, active low, keeps mode |
| fwft_sel | input | 1 | Mode select captured during master reset |
| retx_n | input | 1 | Retransmit request, active low, sampled on rd_clk |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | WIDTH | Registered read data |
| ae_level | input | AW+1 | Almost-empty threshold |
| af_level | input | AW+1 | Almost-full threshold |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | More than half the depth in use |
| almost_full | output | 1 | Free space at or below af_level |
| almost_empty | output | 1 | Stored count at or below ae_level |
| pwr_down | output | 1 | Idle indication |

## Verification
The hardest state to reach from the ports is a partial reset that arrives while the block is in fall-through mode with a word held, and with `fwft_sel` already changed to the other value. Only this state shows that the mode survived the partial reset. The bench reaches it by loading two words in fall-through mode, flipping `fwft_sel`, and pulsing `prst_n`. A later write must then fall through with no read request. Retransmit is checked after part of the data has already been read, so the replay must start from the first location and not from the current read point. The wake behaviour of the idle detector is checked from both sides: by a read enable on the counting clock, and by a write whose pointer change reaches the counting domain only through the synchronizer.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic {RS_IDLE, RS_HELD} rs_state_t;
    typedef enum logic {PD_AWAKE, PD_ASLEEP} pd_state_t;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    input  logic [PW-1:0] af_level,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wbin,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wbin_nx;

    // Gray to binary for the synchronised read pointer
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign wcount      = wbin - rbin_s;
    assign full        = (wcount == PW'(DEPTH));
    assign half_full   = (wcount > PW'(DEPTH / 2));
    assign almost_full = ((PW'(DEPTH) - wcount) <= af_level);
    assign wr_fire     = wr_en && !full;
    assign waddr       = wbin[AW-1:0];
    assign wbin_nx     = wr_fire ? wbin + PW'(1) : wbin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fwft,
    input  logic             rd_en,
    input  logic             retx_n,
    input  logic [PW-1:0]    wgray_s,
    input  logic [PW-1:0]    ae_level,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [PW-1:0]    rbin,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             out_ready,
    output logic             almost_empty
);
    rs_state_t     state, state_nx;
    logic          take;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rbin_nx;

    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign rcount       = wbin_s - rbin;
    assign empty        = (rcount == '0);
    assign almost_empty = (rcount <= ae_level);
    assign raddr        = rbin[AW-1:0];
    assign out_ready    = (state == RS_HELD);

    // next state and word-take decision
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            RS_IDLE: begin
                if (mode_fwft && !empty) begin
                    state_nx = RS_HELD;
                    take     = 1'b1;
                end else if (!mode_fwft && rd_en && !empty) begin
                    take = 1'b1;
                end
            end
            RS_HELD: begin
                if (rd_en) begin
                    if (!empty) take = 1'b1;
                    else        state_nx = RS_IDLE;
                end
            end
        endcase
        if (!retx_n) begin
            state_nx = RS_IDLE;
            take     = 1'b0;
        end
    end

    assign rbin_nx = !retx_n ? '0 : (take ? rbin + PW'(1) : rbin);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // outputs and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            if (take) rd_data <= mem_rdata;
        end
    end
endmodule

// File: rtl/dcf_pwr_ctl.sv
module dcf_pwr_ctl
    import dcf_pkg::*;
#(
    parameter int IDLE_LIMIT = 10,
    parameter int PW = 5,
    localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          local_act,
    input  logic          any_en,
    input  logic [PW-1:0] remote_ptr,
    output logic          sleep
);
    pd_state_t     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [PW-1:0] remote_q;
    logic          act;

    assign act = local_act || (remote_ptr != remote_q);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PD_AWAKE: begin
                if (act) begin
                    cnt_nx = '0;
                end else if (cnt == CW'(IDLE_LIMIT - 1)) begin
                    state_nx = PD_ASLEEP;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            PD_ASLEEP: begin
                if (act) begin
                    state_nx = PD_AWAKE;
                    cnt_nx   = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PD_AWAKE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            remote_q <= '0;
        end else begin
            cnt      <= cnt_nx;
            remote_q <= remote_ptr;
        end
    end

    assign sleep = (state == PD_ASLEEP) && !any_en;
endmodule

// File: rtl/dcfifo_rt.sv
module dcfifo_rt #(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 16,
    parameter int IDLE_LIMIT = 10,
    parameter bit PD_ON_RD   = 1'b1,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic             retx_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [PW-1:0]    ae_level,
    input  logic [PW-1:0]    af_level,
    output logic             full_ir,
    output logic             empty_or,
    output logic             half_full,
    output logic             almost_full,
    output logic             almost_empty,
    output logic             pwr_down
);
    logic             rst_n;
    logic             mode_wr, mode_rd;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    waddr, raddr;
    logic             wr_fire;
    logic [PW-1:0]    wgray, rgray, wgray_rd, rgray_wr;
    logic [PW-1:0]    wbin_w, rbin_r;
    logic             full_w, empty_r, out_ready;
    logic [WIDTH-1:0] mem_rdata;
    logic             any_en;

    assign rst_n  = mrst_n && prst_n;
    assign any_en = wr_en || rd_en;

    // mode captured only while master reset is held
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) mode_wr <= fwft_sel;
    end
    always_ff @(posedge rd_clk) begin
        if (!mrst_n) mode_rd <= fwft_sel;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= wr_data;
    end
    assign mem_rdata = mem[raddr];

    dcf_sync2 #(.W(PW)) u_sync_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rd));
    dcf_sync2 #(.W(PW)) u_sync_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_wr));

    dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rgray_wr),
        .af_level(af_level), .waddr(waddr), .wr_fire(wr_fire), .wgray(wgray),
        .wbin(wbin_w), .full(full_w), .half_full(half_full), .almost_full(almost_full)
    );

    dcf_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .mode_fwft(mode_rd), .rd_en(rd_en),
        .retx_n(retx_n), .wgray_s(wgray_rd), .ae_level(ae_level),
        .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .rbin(rbin_r),
        .rd_data(rd_data), .empty(empty_r), .out_ready(out_ready),
        .almost_empty(almost_empty)
    );

    generate
        if (PD_ON_RD) begin : g_pd_rd
            dcf_pwr_ctl #(.IDLE_LIMIT(IDLE_LIMIT), .PW(PW)) u_pd (
                .clk(rd_clk), .rst_n(rst_n), .local_act(rd_en), .any_en(any_en),
                .remote_ptr(wgray_rd), .sleep(pwr_down)
            );
        end else begin : g_pd_wr
            dcf_pwr_ctl #(.IDLE_LIMIT(IDLE_LIMIT), .PW(PW)) u_pd (
                .clk(wr_clk), .rst_n(rst_n), .local_act(wr_en), .any_en(any_en),
                .remote_ptr(rgray_wr), .sleep(pwr_down)
            );
        end
    endgenerate

    assign full_ir  = mode_wr ? !full_w   : full_w;
    assign empty_or = mode_rd ? out_ready : empty_r;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int W  = 8,
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          retx_n,
    input logic          full_w,
    input logic          empty_r,
    input logic          half_full,
    input logic          almost_full,
    input logic          mode_rd,
    input logic          out_ready,
    input logic [W-1:0]  rd_data,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin,
    input logic          pwr_down
);
    // R3
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full_w && wr_en) |=> $stable(wbin));

    // R3
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!mode_rd && empty_r && rd_en && retx_n) |=> $stable(rbin));

    // R5
    full_flags_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_w |-> (half_full && almost_full));

    // R7
    retx_home_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !retx_n |=> (rbin == '0));

    // R9
    fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (mode_rd && out_ready && !rd_en && retx_n) |=> (out_ready && $stable(rd_data)));

    // R11
    wake_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> !pwr_down);
endmodule

bind dcfifo_rt dcf_chk #(.W(WIDTH), .PW(PW)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .retx_n(retx_n), .full_w(full_w), .empty_r(empty_r), .half_full(half_full),
    .almost_full(almost_full), .mode_rd(mode_rd), .out_ready(out_ready),
    .rd_data(rd_data), .wbin(wbin_w), .rbin(rbin_r), .pwr_down(pwr_down)
);

// File: tb/test_dcfifo_rt.sv
module test_dcfifo_rt;
    localparam int W = 8;
    localparam int D = 16;

    logic         wr_clk = 1'b0, rd_clk = 1'b0;
    logic         mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0, retx_n = 1'b1;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [4:0]   ae_level = 5'd2, af_level = 5'd3;
    logic         full_ir, empty_or, half_full, almost_full, almost_empty, pwr_down;
    int           total = 0, bad = 0;

    always #10 rd_clk = ~rd_clk;   // 50 MHz
    always #14 wr_clk = ~wr_clk;

    dcfifo_rt #(.WIDTH(W), .DEPTH(D)) i_dcfifo_rt (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .retx_n(retx_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ae_level(ae_level), .af_level(af_level),
        .full_ir(full_ir), .empty_or(empty_or), .half_full(half_full),
        .almost_full(almost_full), .almost_empty(almost_empty), .pwr_down(pwr_down)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic fw);
        @(negedge wr_clk);
        fwft_sel = fw;
        mrst_n   = 1'b0;
        repeat (4) @(negedge wr_clk);
        mrst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic push(input logic [W-1:0] v);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(input string req, input logic [W-1:0] exp);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset();
        master_reset(1'b0);
        chk("R1 empty", empty_or, 1);
        chk("R1 full", full_ir, 0);
        chk("R1 half_full", half_full, 0);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        master_reset(1'b0);
        push(8'h11); push(8'h22); push(8'h33);
        settle();
        chk("R4 not empty", empty_or, 0);
        pop("R2 first", 8'h11);
        pop("R2 second", 8'h22);
        pop("R2 third", 8'h33);
        settle();
        chk("R4 empty again", empty_or, 1);
    endtask

    task automatic t_fill();
        master_reset(1'b0);
        for (int k = 1; k <= D; k++) begin
            push(W'(8'h30 + k));
            settle();
            chk("R4 full", full_ir, (k == D));
            chk("R4 empty", empty_or, 0);
            chk("R5 half_full", half_full, (k > D / 2));
            chk("R6 almost_empty", almost_empty, (k <= 2));
            chk("R6 almost_full", almost_full, ((D - k) <= 3));
        end
        push(8'hEE);   // R3: dropped, memory is full
        settle();
        for (int k = 1; k <= D; k++) pop("R3 drain", W'(8'h30 + k));
        settle();
        chk("R3 overflow not stored", empty_or, 1);
        pop("R3 empty read keeps data", W'(8'h30 + D));
    endtask

    task automatic t_retx();
        master_reset(1'b0);
        for (int k = 1; k <= 4; k++) push(W'(8'hA0 + k));
        settle();
        pop("R7 pre", 8'hA1);
        pop("R7 pre", 8'hA2);
        @(negedge rd_clk);
        retx_n = 1'b0;
        @(negedge rd_clk);
        retx_n = 1'b1;
        settle();
        chk("R7 empty after retx", empty_or, 0);
        chk("R7 almost_empty after retx", almost_empty, 0);
        for (int k = 1; k <= 4; k++) pop("R7 replay", W'(8'hA0 + k));
        settle();
        chk("R7 empty after replay", empty_or, 1);
    endtask

    task automatic t_fwft();
        master_reset(1'b1);
        chk("R1 fwft out-ready", empty_or, 0);
        chk("R9 input-ready", full_ir, 1);
        push(8'h51); push(8'h52);
        settle();
        chk("R9 falls through", rd_data, 8'h51);
        chk("R9 out-ready", empty_or, 1);
        pop("R9 advance", 8'h52);
        chk("R9 still ready", empty_or, 1);
        pop("R9 last held", 8'h52);
        chk("R9 ready cleared", empty_or, 0);
    endtask

    task automatic t_partial();
        master_reset(1'b1);
        push(8'h61); push(8'h62);
        settle();
        chk("R9 word shown", rd_data, 8'h61);
        @(negedge wr_clk);
        fwft_sel = 1'b0;
        prst_n   = 1'b0;
        repeat (3) @(negedge wr_clk);
        prst_n = 1'b1;
        settle();
        chk("R8 out-ready cleared", empty_or, 0);
        chk("R8 input-ready", full_ir, 1);
        chk("R8 rd_data cleared", rd_data, 0);
        chk("R8 half_full cleared", half_full, 0);
        push(8'h63);
        settle();
        chk("R8 mode kept, falls through", rd_data, 8'h63);
        chk("R8 mode kept, out-ready", empty_or, 1);
        master_reset(1'b0);
        push(8'h70);
        settle();
        chk("R1 standard mode back", empty_or, 0);
        chk("R1 no fall through", rd_data, 0);
    endtask

    task automatic t_power();
        master_reset(1'b0);
        repeat (3) @(negedge rd_clk);
        chk("R10 awake early", pwr_down, 0);
        repeat (8) @(negedge rd_clk);
        chk("R10 asleep", pwr_down, 1);
        @(negedge rd_clk);
        rd_en = 1'b1;
        #1 chk("R11 rd_en wakes", pwr_down, 0);
        @(negedge rd_clk);
        rd_en = 1'b0;
        #1 chk("R11 stays awake", pwr_down, 0);
        repeat (14) @(negedge rd_clk);
        chk("R10 asleep again", pwr_down, 1);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = 8'h7A;
        #1 chk("R11 wr_en wakes", pwr_down, 0);
        @(negedge wr_clk);
        wr_en = 1'b0;
        repeat (4) @(negedge rd_clk);
        chk("R11 write keeps awake", pwr_down, 0);
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_fill();
        t_retx();
        t_fwft();
        t_partial();
        t_power();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule